// File: doc/BRIEF.md
# Reference-Pulse Tail Subtraction Unit

This unit sits in a pile-up correction engine after pulse timing and amplitude normalisation. Once a pulse has been found, a controller arms the unit with three values: a fine time offset (in reference steps), an unsigned Q1.15 amplitude scale, and the number of leading samples that the engine keeps for itself. For each later sample of the ADC stream, the unit reads the expected tail value from a finely sampled reference-pulse memory. It scales that value, subtracts it from the sample with saturation, and forwards the residual at once to the next engine. When no second pulse overlaps the tail, the residual is flat.

The reference memory is outside the block and is reached through one read port of a shared dual-port RAM with a registered read, so a second engine can use the other port. The address for pulse sample index k is k times the resolution ratio, plus the fine offset. Subtraction starts at the cutoff index and stops once the address runs past the last reference entry. From that sample on, the stream passes through unchanged and the unit reports the sum of everything it subtracted as the interpolated tail energy.

Top module: `tsu_tail_subtract`

## Requirements
- R1: While reset is held, and in the first cycle after it, `res_valid`, `tail_energy_valid` and `ref_rd_en` are 0.
- R2: Each cycle with `in_valid`=1 yields exactly one `res_valid` pulse exactly LATENCY = 3 + OUT_STAGES clock cycles later. No other cycle raises `res_valid`, and residuals keep input order.
- R3: Sample index k counts valid samples from the arm point, starting at 0. A tail sample issues `ref_rd_en`=1 in its own input cycle, with `ref_rd_addr` = k*RATIO + offset.
- R4: Samples of an armed pulse with k below the cutoff are forwarded unchanged, with no memory read.
- R5: For a tail sample with reference value r and scale s (unsigned, 15 fraction bits), the subtracted value is floor((r*s + 16384) / 32768). The residual is sample minus that value.
- R6: The residual saturates to the signed SAMP_W range, from -2^(SAMP_W-1) to 2^(SAMP_W-1)-1.
- R7: The pulse ends at the first valid sample whose address k*RATIO+offset is at least DEPTH. That sample and all later samples, up to the next arm, are forwarded unchanged. Samples before any arm also pass unchanged.
- R8: The end sample's residual carries `tail_energy_valid`=1 in the same cycle. `tail_energy` then equals the signed sum of all values subtracted for that pulse.
- R9: An arm before the current pulse has ended restarts the index at 0 with the new offset, scale and cutoff. The unfinished pulse's energy is dropped and never reported.
- R10: An arm that coincides with the end sample of the running pulse still reports that pulse's energy. The same sample is then index 0 of the new pulse.
- R11: Cycles with `in_valid`=0 do not advance the index. An arm given in such a cycle makes the next valid sample index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | ADC sample present this cycle |
| in_sample | input | SAMP_W | Signed baseline-removed ADC sample |
| arm | input | 1 | Start a new pulse; applies to the sample in this cycle if valid |
| arm_offset | input | OFF_W | Fine timestamp offset in reference steps |
| arm_scale | input | 16 | Unsigned Q1.15 amplitude ratio |
| arm_cutoff | input | CUT_W | Index of the first sample to subtract from |
| ref_rd_en | output | 1 | Reference memory read request |
| ref_rd_addr | output | log2(DEPTH) | Reference memory read address |
| ref_rd_data | input | REF_W | Signed reference value, one cycle after the request |
| res_valid | output | 1 | Residual sample present |
| res_sample | output | SAMP_W | Signed residual sample |
| tail_energy_valid | output | 1 | Tail energy report for the pulse that just ended |
| tail_energy | output | ACC_W | Signed sum of the subtracted tail values |

## Verification
Two events can meet in one cycle: the end of one pulse and the arm of the next. The bench arms a new pulse exactly on the sample whose address first passes the memory end. It then expects the energy report for the old pulse on that sample's residual, while the same sample is already treated as index 0 of the new pulse with the new scale and offset. A second collision arms a new pulse in mid-tail, where the old energy must never appear. The scoreboard checks each residual for value and arrival cycle, and checks each energy report against a model of the requirements.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    // amplitude ratio format: unsigned, one integer bit, fifteen fraction bits
    localparam int SCALE_W = 16;
    localparam int FRAC_W  = 15;

    // registers from input sample to residual without extra output stages:
    // index/read issue, scale, subtract
    localparam int CORE_LAT = 3;

    // per-sample control token travelling beside the datapath
    typedef struct packed {
        logic vld;    // a sample occupies this slot
        logic tail;   // a reference value was fetched for it
        logic first;  // first valid sample of a freshly armed pulse
        logic last;   // sample at which the running pulse ended
    } tok_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tsu_index_gen.sv
module tsu_index_gen
    import tsu_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int RATIO = 64,
    parameter int OFF_W = 6,
    parameter int CUT_W = 6,
    parameter int AW    = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               arm,
    input  logic [OFF_W-1:0]   arm_offset,
    input  logic [SCALE_W-1:0] arm_scale,
    input  logic [CUT_W-1:0]   arm_cutoff,
    output tok_t               tok,
    output logic [SCALE_W-1:0] scale_cur,
    output logic               rd_en,
    output logic [AW-1:0]      rd_addr
);

    // index needs to reach just past the end of the reference memory
    localparam int K_W  = $clog2(DEPTH / RATIO + 2) + 1;
    localparam int RB   = $clog2(RATIO) + 1;
    localparam int ADW  = max2(max2(K_W + RB + 1, CUT_W), OFF_W) + 1;
    localparam logic [K_W-1:0] K_MAX = '1;

    logic               act_q, first_q;
    logic [K_W-1:0]     k_q;
    logic [OFF_W-1:0]   off_q;
    logic [SCALE_W-1:0] scl_q;
    logic [CUT_W-1:0]   cut_q;

    logic               act_c;
    logic [K_W-1:0]     k_c;
    logic [OFF_W-1:0]   off_c;
    logic [CUT_W-1:0]   cut_c;
    logic [ADW-1:0]     old_addr, cur_addr;
    logic               end_hit, tail_hit, first_hit;

    always_comb begin
        // context that applies to the sample of this cycle
        act_c     = arm ? 1'b1       : act_q;
        k_c       = arm ? '0         : k_q;
        off_c     = arm ? arm_offset : off_q;
        cut_c     = arm ? arm_cutoff : cut_q;
        scale_cur = arm ? arm_scale  : scl_q;

        // end detection always looks at the pulse that was running
        old_addr  = ADW'(k_q) * ADW'(RATIO) + ADW'(off_q);
        cur_addr  = ADW'(k_c) * ADW'(RATIO) + ADW'(off_c);
        end_hit   = in_valid && act_q && (old_addr >= ADW'(DEPTH));
        tail_hit  = in_valid && act_c && (ADW'(k_c) >= ADW'(cut_c))
                    && (cur_addr < ADW'(DEPTH));
        first_hit = in_valid && (arm || first_q);

        tok.vld   = in_valid;
        tok.tail  = tail_hit;
        tok.first = first_hit;
        tok.last  = end_hit;
        rd_en     = tail_hit;
        rd_addr   = cur_addr[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            first_q <= 1'b0;
            k_q     <= '0;
            off_q   <= '0;
            scl_q   <= '0;
            cut_q   <= '0;
        end else begin
            off_q   <= off_c;
            cut_q   <= cut_c;
            scl_q   <= scale_cur;
            if (arm)
                act_q <= 1'b1;
            else if (end_hit)
                act_q <= 1'b0;
            if (in_valid)
                first_q <= 1'b0;
            else if (arm)
                first_q <= 1'b1;
            if (in_valid && act_c && (k_c != K_MAX))
                k_q <= k_c + 1'b1;
            else
                k_q <= k_c;
        end
    end

endmodule

// File: rtl/tsu_scaler.sv
module tsu_scaler
    import tsu_pkg::*;
#(
    parameter int SAMP_W = 14,
    parameter int REF_W  = 16,
    parameter int T_W    = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  tok_t                     tok_in,
    input  logic signed [SAMP_W-1:0] smp_in,
    input  logic [SCALE_W-1:0]       scl_in,
    input  logic signed [REF_W-1:0]  ref_data,
    output tok_t                     tok_out,
    output logic signed [SAMP_W-1:0] smp_out,
    output logic signed [T_W-1:0]    tail_out
);

    localparam int P_W = REF_W + SCALE_W + 1;

    // stage one: aligned with the registered read of the reference memory
    tok_t                     tok1;
    logic signed [SAMP_W-1:0] smp1;
    logic [SCALE_W-1:0]       scl1;

    logic signed [P_W-1:0]    prod, rnd;
    logic signed [T_W-1:0]    tail_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            tok1 <= '0;
            smp1 <= '0;
            scl1 <= '0;
        end else begin
            tok1 <= tok_in;
            smp1 <= smp_in;
            scl1 <= scl_in;
        end
    end

    always_comb begin
        prod   = P_W'(ref_data) * $signed({1'b0, scl1});
        rnd    = prod + (P_W'(1) <<< (FRAC_W - 1));
        tail_c = tok1.tail ? T_W'(rnd >>> FRAC_W) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_out  <= '0;
            smp_out  <= '0;
            tail_out <= '0;
        end else begin
            tok_out  <= tok1;
            smp_out  <= smp1;
            tail_out <= tail_c;
        end
    end

endmodule

// File: rtl/tsu_residual.sv
module tsu_residual
    import tsu_pkg::*;
#(
    parameter int SAMP_W = 14,
    parameter int T_W    = 18,
    parameter int ACC_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  tok_t                     tok,
    input  logic signed [SAMP_W-1:0] smp,
    input  logic signed [T_W-1:0]    tail,
    output logic                     out_vld,
    output logic signed [SAMP_W-1:0] out_smp,
    output logic                     out_ev,
    output logic signed [ACC_W-1:0]  out_energy
);

    localparam int DW = max2(SAMP_W, T_W) + 1;
    localparam logic signed [DW-1:0] HI = DW'((64'sd1 <<< (SAMP_W - 1)) - 64'sd1);
    localparam logic signed [DW-1:0] LO = -HI - DW'(1);

    logic signed [DW-1:0]     diff;
    logic signed [SAMP_W-1:0] sat;
    logic signed [ACC_W-1:0]  acc_q;

    always_comb begin
        diff = DW'(smp) - DW'(tail);
        if (diff > HI)
            sat = SAMP_W'(HI);
        else if (diff < LO)
            sat = SAMP_W'(LO);
        else
            sat = SAMP_W'(diff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld    <= 1'b0;
            out_smp    <= '0;
            out_ev     <= 1'b0;
            out_energy <= '0;
            acc_q      <= '0;
        end else begin
            out_vld <= tok.vld;
            out_smp <= sat;
            out_ev  <= tok.vld && tok.last;
            if (tok.vld && tok.last)
                out_energy <= acc_q;
            if (tok.vld)
                acc_q <= tok.first ? ACC_W'(tail) : acc_q + ACC_W'(tail);
        end
    end

endmodule

// File: rtl/tsu_out_delay.sv
module tsu_out_delay #(
    parameter int W      = 8,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] pipe [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < STAGES; s++)
                        pipe[s] <= '0;
                end else begin
                    pipe[0] <= d;
                    for (int s = 1; s < STAGES; s++)
                        pipe[s] <= pipe[s-1];
                end
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tsu_tail_subtract.sv
module tsu_tail_subtract
    import tsu_pkg::*;
#(
    parameter int SAMP_W     = 14,
    parameter int REF_W      = 16,
    parameter int DEPTH      = 1024,
    parameter int RATIO      = 64,
    parameter int OFF_W      = 6,
    parameter int CUT_W      = 6,
    parameter int ACC_W      = 32,
    parameter int OUT_STAGES = 0,
    parameter int AW         = $clog2(DEPTH),
    parameter int LATENCY    = CORE_LAT + OUT_STAGES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_sample,
    input  logic                     arm,
    input  logic [OFF_W-1:0]         arm_offset,
    input  logic [SCALE_W-1:0]       arm_scale,
    input  logic [CUT_W-1:0]         arm_cutoff,
    output logic                     ref_rd_en,
    output logic [AW-1:0]            ref_rd_addr,
    input  logic signed [REF_W-1:0]  ref_rd_data,
    output logic                     res_valid,
    output logic signed [SAMP_W-1:0] res_sample,
    output logic                     tail_energy_valid,
    output logic signed [ACC_W-1:0]  tail_energy
);

    localparam int T_W  = REF_W + 2;
    localparam int PL_W = 1 + SAMP_W + 1 + ACC_W;

    tok_t                     tok0, tok2;
    logic [SCALE_W-1:0]       scl0;
    logic signed [SAMP_W-1:0] smp2;
    logic signed [T_W-1:0]    tail2;
    logic                     core_vld, core_ev;
    logic signed [SAMP_W-1:0] core_smp;
    logic signed [ACC_W-1:0]  core_energy;
    logic [PL_W-1:0]          pl_in, pl_out;

    tsu_index_gen #(
        .DEPTH(DEPTH), .RATIO(RATIO), .OFF_W(OFF_W), .CUT_W(CUT_W), .AW(AW)
    ) u_idx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .arm(arm),
        .arm_offset(arm_offset), .arm_scale(arm_scale), .arm_cutoff(arm_cutoff),
        .tok(tok0), .scale_cur(scl0), .rd_en(ref_rd_en), .rd_addr(ref_rd_addr)
    );

    tsu_scaler #(
        .SAMP_W(SAMP_W), .REF_W(REF_W), .T_W(T_W)
    ) u_scl (
        .clk(clk), .rst(rst), .tok_in(tok0), .smp_in(in_sample), .scl_in(scl0),
        .ref_data(ref_rd_data), .tok_out(tok2), .smp_out(smp2), .tail_out(tail2)
    );

    tsu_residual #(
        .SAMP_W(SAMP_W), .T_W(T_W), .ACC_W(ACC_W)
    ) u_res (
        .clk(clk), .rst(rst), .tok(tok2), .smp(smp2), .tail(tail2),
        .out_vld(core_vld), .out_smp(core_smp), .out_ev(core_ev),
        .out_energy(core_energy)
    );

    assign pl_in = {core_vld, core_smp, core_ev, core_energy};

    tsu_out_delay #(
        .W(PL_W), .STAGES(OUT_STAGES)
    ) u_dly (
        .clk(clk), .rst(rst), .d(pl_in), .q(pl_out)
    );

    assign {res_valid, res_sample, tail_energy_valid, tail_energy} = pl_out;

endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
    parameter int CUT_W   = 6,
    parameter int LATENCY = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             arm,
    input logic [CUT_W-1:0] arm_cutoff,
    input logic             ref_rd_en,
    input logic             res_valid,
    input logic             tail_energy_valid
);

    localparam int PW = $clog2(LATENCY + 2) + 2;

    // samples accepted but not yet emitted
    logic [PW-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= pend_q + PW'(in_valid) - PW'(res_valid);
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !tail_energy_valid));

    p_out_has_source_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (pend_q != '0));

    p_read_needs_sample_r3: assert property (@(posedge clk) disable iff (rst)
        ref_rd_en |-> in_valid);

    p_no_read_before_cut_r4: assert property (@(posedge clk) disable iff (rst)
        (arm && in_valid && (arm_cutoff != '0)) |-> !ref_rd_en);

    p_energy_on_sample_r8: assert property (@(posedge clk) disable iff (rst)
        tail_energy_valid |-> res_valid);

endmodule

bind tsu_tail_subtract tsu_checker #(
    .CUT_W(CUT_W), .LATENCY(LATENCY)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .arm(arm),
    .arm_cutoff(arm_cutoff), .ref_rd_en(ref_rd_en), .res_valid(res_valid),
    .tail_energy_valid(tail_energy_valid)
);

// File: tb/sim_tsu_tail_subtract.sv
module sim_tsu_tail_subtract;

    localparam int SAMP_W = 14;
    localparam int REF_W  = 16;
    localparam int DEPTH  = 256;
    localparam int RATIO  = 16;
    localparam int OFF_W  = 4;
    localparam int CUT_W  = 5;
    localparam int ACC_W  = 32;
    localparam int OUT_ST = 1;
    localparam int AW     = 8;
    localparam int LAT    = tsu_pkg::CORE_LAT + OUT_ST;
    localparam longint SMAX = (64'sd1 <<< (SAMP_W - 1)) - 1;
    localparam longint SMIN = -SMAX - 1;

    logic                     clk = 1'b0;
    logic                     rst;
    logic                     in_valid;
    logic signed [SAMP_W-1:0] in_sample;
    logic                     arm;
    logic [OFF_W-1:0]         arm_offset;
    logic [15:0]              arm_scale;
    logic [CUT_W-1:0]         arm_cutoff;
    logic                     ref_rd_en;
    logic [AW-1:0]            ref_rd_addr;
    logic signed [REF_W-1:0]  ref_rd_data;
    logic                     res_valid;
    logic signed [SAMP_W-1:0] res_sample;
    logic                     tail_energy_valid;
    logic signed [ACC_W-1:0]  tail_energy;

    always #4 clk = ~clk;

    tsu_tail_subtract #(
        .SAMP_W(SAMP_W), .REF_W(REF_W), .DEPTH(DEPTH), .RATIO(RATIO),
        .OFF_W(OFF_W), .CUT_W(CUT_W), .ACC_W(ACC_W), .OUT_STAGES(OUT_ST)
    ) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .arm(arm), .arm_offset(arm_offset), .arm_scale(arm_scale),
        .arm_cutoff(arm_cutoff), .ref_rd_en(ref_rd_en), .ref_rd_addr(ref_rd_addr),
        .ref_rd_data(ref_rd_data), .res_valid(res_valid), .res_sample(res_sample),
        .tail_energy_valid(tail_energy_valid), .tail_energy(tail_energy)
    );

    // reference pulse: rising ramp, then a falling slope crossing below zero
    function automatic longint ref_val(longint a);
        return (a < 32) ? a * 900 : 28800 - (a - 32) * 175;
    endfunction

    // memory model with a registered read
    always @(posedge clk)
        if (ref_rd_en)
            ref_rd_data <= REF_W'(ref_val(longint'(ref_rd_addr)));

    typedef struct {
        longint val;
        longint stamp;
        string  req;
    } item_t;

    item_t  res_q[$];
    item_t  en_q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    longint cyc = 0;
    bit     done = 1'b0;

    // requirement model state
    bit     m_act = 1'b0, m_first = 1'b0;
    longint m_k = 0, m_off = 0, m_scl = 0, m_cut = 0, m_acc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle and push the expected results
    task automatic step(bit v, longint smp, bit a, longint off, longint scl,
                        longint cut, string ctx);
        bit     end_hit, tail, exp_en;
        longint ca, tl, diff, res;
        string  base;
        item_t  it;
        @(negedge clk);
        in_valid   = v;
        in_sample  = SAMP_W'(smp);
        arm        = a;
        arm_offset = OFF_W'(off);
        arm_scale  = 16'(scl);
        arm_cutoff = CUT_W'(cut);

        end_hit = v && m_act && (m_k * RATIO + m_off >= DEPTH);
        if (a) begin
            m_act = 1'b1; m_k = 0; m_off = off; m_scl = scl; m_cut = cut;
            m_first = 1'b1;
        end
        ca     = m_k * RATIO + m_off;
        tail   = v && m_act && (m_k >= m_cut) && (ca < DEPTH);
        exp_en = tail;
        if (v) begin
            tl   = tail ? ((ref_val(ca) * m_scl + 16384) >>> 15) : 0;
            diff = smp - tl;
            res  = (diff > SMAX) ? SMAX : ((diff < SMIN) ? SMIN : diff);
            if (tail)
                base = (res != diff) ? "R6" : "R5";
            else if (m_act && !end_hit && m_k < m_cut)
                base = "R4";
            else
                base = "R7";
            it.val = res; it.stamp = cyc + LAT; it.req = {base, " ", ctx};
            res_q.push_back(it);
            if (end_hit) begin
                it.val = m_acc; it.stamp = cyc + LAT;
                it.req = a ? {"R10 ", ctx} : {"R8 ", ctx};
                en_q.push_back(it);
            end
            m_acc   = m_first ? tl : m_acc + tl;
            m_first = 1'b0;
            if (end_hit && !a)
                m_act = 1'b0;
            if (m_act)
                m_k++;
        end
        #1;
        check(ref_rd_en == exp_en, {"R3 rd_en ", ctx}, ref_rd_en, exp_en);
        if (exp_en)
            check(longint'(ref_rd_addr) == ca, {"R3 addr ", ctx}, ref_rd_addr, ca);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++)
            step(1'b0, 0, 1'b0, 0, 0, 0, "gap");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        item_t e;
        if (!rst && !done) begin
            if (res_valid) begin
                if (res_q.size() == 0) begin
                    check(1'b0, "R2 unexpected residual", 1, 0);
                end else begin
                    e = res_q.pop_front();
                    check(cyc == e.stamp, {"R2 timing ", e.req}, cyc, e.stamp);
                    check(longint'(res_sample) == e.val, e.req, res_sample, e.val);
                end
            end
            if (tail_energy_valid) begin
                if (en_q.size() == 0) begin
                    check(1'b0, "R9 unexpected energy report", 1, 0);
                end else begin
                    e = en_q.pop_front();
                    check(cyc == e.stamp, {"R8 timing ", e.req}, cyc, e.stamp);
                    check(longint'(tail_energy) == e.val, e.req, tail_energy, e.val);
                end
            end else if (en_q.size() != 0 && en_q[0].stamp <= cyc) begin
                check(1'b0, {"R8 missing report ", en_q[0].req}, 0, 1);
                void'(en_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sample = '0; arm = 1'b0;
        arm_offset = '0; arm_scale = '0; arm_cutoff = '0;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        check(tail_energy_valid == 1'b0, "R1 energy_valid", tail_energy_valid, 0);
        check(ref_rd_en == 1'b0, "R1 rd_en", ref_rd_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 after release", res_valid, 0);

        // R7: nothing armed yet, stream passes unchanged
        for (int i = 0; i < 4; i++)
            step(1'b1, i * 111 - 200, 1'b0, 0, 0, 0, "idle");

        // pulse A, with gaps between samples (R11)
        step(1'b1, 100, 1'b1, 5, 8192, 3, "A");
        for (int i = 1; i < 20; i++) begin
            if (i % 4 == 0)
                idle(1);
            step(1'b1, (i * 37) % 500 - 250, 1'b0, 0, 0, 0, "A R11");
        end
        idle(2);

        // pulse B: unit scale, driven into both saturation limits (R6)
        step(1'b1, 50, 1'b1, 0, 32768, 2, "B");
        for (int i = 1; i < 18; i++)
            step(1'b1, (i < 2) ? 50 : (i < 9) ? -8000 : (i < 13) ? 0 : 8000,
                 1'b0, 0, 0, 0, "B");
        idle(1);

        // pulse C: re-armed mid-tail, first energy dropped (R9)
        step(1'b1, 10, 1'b1, 3, 20000, 1, "C R9");
        for (int i = 1; i < 6; i++)
            step(1'b1, i * 300, 1'b0, 0, 0, 0, "C R9");
        step(1'b1, -77, 1'b1, 7, 12345, 0, "C2 R9");
        for (int i = 1; i < 18; i++)
            step(1'b1, 1000 - i * 97, 1'b0, 0, 0, 0, "C2 R9");
        idle(1);

        // pulse D: full scale, new arm exactly on the end sample (R10)
        step(1'b1, 0, 1'b1, 0, 65535, 4, "D");
        for (int i = 1; i < 16; i++)
            step(1'b1, i * 13, 1'b0, 0, 0, 0, "D");
        step(1'b1, 500, 1'b1, 9, 3000, 0, "D2 R10");
        for (int i = 1; i < 18; i++)
            step(1'b1, -i * 41, 1'b0, 0, 0, 0, "D2 R10");

        // pulse E: armed in a gap cycle, index starts at next sample (R11)
        step(1'b0, 0, 1'b1, 2, 16385, 1, "E R11");
        idle(2);
        for (int i = 0; i < 18; i++)
            step(1'b1, 250 - i * 5, 1'b0, 0, 0, 0, "E R11");

        idle(LAT + 4);
        check(res_q.size() == 0, "R2 residuals outstanding", res_q.size(), 0);
        check(en_q.size() == 0, "R8 reports outstanding", en_q.size(), 0);
        finish_run();
    end

endmodule